// File: doc/BRIEF.md
# Register-Transfer Micro-Operation Datapath

This block is a small register-transfer datapath: a bank of general registers (four of eight bits by default), a single arithmetic/logic/shift unit and a write-back path. On every rising edge of one free-running clock it can perform one micro-operation. The function code picks the operation. Two source selects name operands A and B, and a destination select names the register that receives the result. Any register may act as either source and as the destination, and the same register may be source and destination in one operation.

A transfer fires only when its control expression is true. In this block the control expression is the OR of two control inputs, `k_one` and `k_two`. When the expression is false, or when the reserved function code is applied, every register reloads its own value through a hold multiplexer. The clock is never gated. A registered carry flag records the carry out of the add, subtract, increment and decrement operations. A separate priority-transfer operation copies source A when `k_one` is high, and otherwise copies source B when only `k_two` is high.

Top module: `rtx_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register and `carry_out` become 0 after that edge.
- R2: When `k_one` and `k_two` are both 0 at an edge, no register and not `carry_out` changes.
- R3: When a transfer fires, only the register named by `dst` may change. All other registers keep their values.
- R4: Function 2 (add/subtract): with `x_mode`=0 the destination gets A+B. With `x_mode`=1 it gets A + NOT B + 1, which is A−B. Both results are modulo 2^DATA_W.
- R5: Function 3 gives NOT A (ones complement). Function 4 gives NOT A + 1 (twos complement). Function 5 gives B + NOT A + 1, which is B−A.
- R6: Function 6 gives A+1 and function 7 gives A−1, both modulo 2^DATA_W, so 0xFF+1 = 0x00 and 0x00−1 = 0xFF.
- R7: Functions 8, 9, 10 and 11 give A AND B, A OR B, A XOR B and NOT A on the whole word. With A=0xAA and B=0xF0, these are 0xA0, 0xFA and 0x5A.
- R8: Function 12 shifts A left by one bit and function 13 shifts A right by one bit. Both fill the vacated bit with 0, so 0xC9 gives 0x92 and 0x64.
- R9: Function 14 (priority transfer) loads source A when `k_one`=1, regardless of `k_two`. It loads source B when `k_one`=0 and `k_two`=1.
- R10: `carry_out` takes the carry out of the top bit for functions 2, 5, 6 and 7 when they fire. Subtraction gives carry 1 when no borrow occurs. All other functions leave `carry_out` unchanged.
- R11: Function 0 copies source A and function 1 loads `data_in` into the destination. Any register may be source or destination, including the same register for both.
- R12: Function 15 is reserved: it changes no register and not `carry_out`, even when the control expression is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| k_one | input | 1 | Control input 1; has priority in function 14 |
| k_two | input | 1 | Control input 2 |
| x_mode | input | 1 | Selects add (0) or subtract (1) for function 2 |
| func | input | 4 | Micro-operation code |
| src_a | input | SEL_W (2) | Register index of operand A |
| src_b | input | SEL_W (2) | Register index of operand B |
| dst | input | SEL_W (2) | Register index of the destination |
| data_in | input | DATA_W (8) | External value for function 1 |
| regs_out | output | NUM_REGS*DATA_W (32) | All registers; register i occupies bits [i*DATA_W +: DATA_W] |
| carry_out | output | 1 | Registered carry flag |

## Verification
Every register is visible on `regs_out`. A wrong operand choice, a wrong result or a write to the wrong register therefore shows as a wrong word one edge after the transfer. It is caught then, not when the value is consumed later. A carry flag that is updated when it should hold, or held when it should update, shows on `carry_out` in that same cycle. The bench compares all registers and the flag against its own model after every clock. A fault that only corrupts state can therefore not hide for more than one cycle.

// File: rtl/rtx_pkg.sv
`timescale 1ns/1ps
package rtx_pkg;

   typedef enum logic [3:0] {
      OP_PASS    = 4'd0,
      OP_LOAD    = 4'd1,
      OP_ADDSUB  = 4'd2,
      OP_COMP1   = 4'd3,
      OP_COMP2   = 4'd4,
      OP_BSUBA   = 4'd5,
      OP_INC     = 4'd6,
      OP_DEC     = 4'd7,
      OP_AND     = 4'd8,
      OP_OR      = 4'd9,
      OP_XOR     = 4'd10,
      OP_NOT     = 4'd11,
      OP_SHL     = 4'd12,
      OP_SHR     = 4'd13,
      OP_PRIXFER = 4'd14,
      OP_NONE    = 4'd15
   } rtx_op_e;

   function automatic logic op_sets_carry(logic [3:0] f);
      return (f == OP_ADDSUB) || (f == OP_BSUBA) || (f == OP_INC) || (f == OP_DEC);
   endfunction

   function automatic logic op_writes(logic [3:0] f);
      return f != OP_NONE;
   endfunction

   function automatic logic op_is_bitwise(logic [3:0] f);
      return (f == OP_AND) || (f == OP_OR) || (f == OP_XOR) || (f == OP_NOT) ||
             (f == OP_SHL) || (f == OP_SHR);
   endfunction

endpackage

// File: rtl/rtx_regbank.sv
`timescale 1ns/1ps
module rtx_regbank #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_sel,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] q;
         logic [DATA_W-1:0] d_next;
         logic              take;

         assign take = wr_en && (wr_sel == SEL_W'(gi));

         // hold multiplexer: feed back own value unless selected
         always_comb begin
            if (take) d_next = wr_data;
            else      d_next = q;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d_next;
         end

         assign regs_flat[gi*DATA_W +: DATA_W] = q;
      end
   endgenerate

endmodule

// File: rtl/rtx_bitops.sv
`timescale 1ns/1ps
module rtx_bitops #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] and_w,
   output logic [DATA_W-1:0] or_w,
   output logic [DATA_W-1:0] xor_w,
   output logic [DATA_W-1:0] not_w,
   output logic [DATA_W-1:0] shl_w,
   output logic [DATA_W-1:0] shr_w
);

   genvar gb;
   generate
      for (gb = 0; gb < DATA_W; gb++) begin : g_bit
         assign and_w[gb] = opnd_a[gb] & opnd_b[gb];
         assign or_w[gb]  = opnd_a[gb] | opnd_b[gb];
         assign xor_w[gb] = opnd_a[gb] ^ opnd_b[gb];
         assign not_w[gb] = ~opnd_a[gb];
         if (gb == 0) begin : g_lsb
            assign shl_w[gb] = 1'b0;
         end else begin : g_lsh
            assign shl_w[gb] = opnd_a[gb-1];
         end
         if (gb == DATA_W-1) begin : g_msb
            assign shr_w[gb] = 1'b0;
         end else begin : g_rsh
            assign shr_w[gb] = opnd_a[gb+1];
         end
      end
   endgenerate

endmodule

// File: rtl/rtx_alu.sv
`timescale 1ns/1ps
module rtx_alu
   import rtx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [3:0]        func,
   input  logic              x_mode,
   input  logic              k_one,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] ext_data,
   output logic [DATA_W-1:0] result,
   output logic              carry
);

   localparam logic [DATA_W-1:0] ALL_ONES = '1;
   localparam logic [DATA_W:0]   ONE_W    = {{DATA_W{1'b0}}, 1'b1};

   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] and_w, or_w, xor_w, not_w, shl_w, shr_w;

   rtx_bitops #(.DATA_W(DATA_W)) u_bitops (
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .and_w  (and_w),
      .or_w   (or_w),
      .xor_w  (xor_w),
      .not_w  (not_w),
      .shl_w  (shl_w),
      .shr_w  (shr_w)
   );

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] add_p;
         logic [DATA_W-1:0] add_q;
         logic              add_c;

         always_comb begin
            add_p = opnd_a;
            add_q = '0;
            add_c = 1'b0;
            case (func)
               OP_ADDSUB: begin
                  add_q = x_mode ? ~opnd_b : opnd_b;
                  add_c = x_mode;
               end
               OP_COMP2: begin
                  add_p = '0;
                  add_q = ~opnd_a;
                  add_c = 1'b1;
               end
               OP_BSUBA: begin
                  add_p = opnd_b;
                  add_q = ~opnd_a;
                  add_c = 1'b1;
               end
               OP_INC:  add_c = 1'b1;
               OP_DEC:  add_q = ALL_ONES;
               default: ;
            endcase
         end

         assign sum = {1'b0, add_p} + {1'b0, add_q} + {{DATA_W{1'b0}}, add_c};
      end else begin : g_split
         logic [DATA_W:0] s_add, s_sub, s_neg, s_bsa, s_inc, s_dec;

         assign s_add = {1'b0, opnd_a} + {1'b0, opnd_b};
         assign s_sub = {1'b0, opnd_a} + {1'b0, ~opnd_b} + ONE_W;
         assign s_neg = {1'b0, ~opnd_a} + ONE_W;
         assign s_bsa = {1'b0, opnd_b} + {1'b0, ~opnd_a} + ONE_W;
         assign s_inc = {1'b0, opnd_a} + ONE_W;
         assign s_dec = {1'b0, opnd_a} + {1'b0, ALL_ONES};

         always_comb begin
            case (func)
               OP_ADDSUB: sum = x_mode ? s_sub : s_add;
               OP_COMP2:  sum = s_neg;
               OP_BSUBA:  sum = s_bsa;
               OP_INC:    sum = s_inc;
               OP_DEC:    sum = s_dec;
               default:   sum = '0;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (func)
         OP_PASS:    result = opnd_a;
         OP_LOAD:    result = ext_data;
         OP_ADDSUB,
         OP_COMP2,
         OP_BSUBA,
         OP_INC,
         OP_DEC:     result = sum[DATA_W-1:0];
         OP_COMP1:   result = not_w;
         OP_AND:     result = and_w;
         OP_OR:      result = or_w;
         OP_XOR:     result = xor_w;
         OP_NOT:     result = not_w;
         OP_SHL:     result = shl_w;
         OP_SHR:     result = shr_w;
         OP_PRIXFER: result = k_one ? opnd_a : opnd_b;
         default:    result = opnd_a;
      endcase
   end

   assign carry = sum[DATA_W];

endmodule

// File: rtl/rtx_datapath.sv
`timescale 1ns/1ps
module rtx_datapath
   import rtx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int NUM_REGS     = 4,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int SEL_W       = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       k_one,
   input  logic                       k_two,
   input  logic                       x_mode,
   input  logic [3:0]                 func,
   input  logic [SEL_W-1:0]           src_a,
   input  logic [SEL_W-1:0]           src_b,
   input  logic [SEL_W-1:0]           dst,
   input  logic [DATA_W-1:0]          data_in,
   output logic [NUM_REGS*DATA_W-1:0] regs_out,
   output logic                       carry_out
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rtx_datapath: DATA_W must be at least 2");
      end
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_count
         $error("rtx_datapath: NUM_REGS must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] rd [NUM_REGS];
   logic [DATA_W-1:0] opnd_a, opnd_b, alu_res;
   logic              alu_carry;
   logic              ctrl_true;
   logic              wr_en;
   logic              carry_q;

   genvar gu;
   generate
      for (gu = 0; gu < NUM_REGS; gu++) begin : g_unpack
         assign rd[gu] = regs_out[gu*DATA_W +: DATA_W];
      end
   endgenerate

   assign opnd_a    = rd[src_a];
   assign opnd_b    = rd[src_b];
   assign ctrl_true = k_one | k_two;
   assign wr_en     = ctrl_true & op_writes(func);

   rtx_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .func     (func),
      .x_mode   (x_mode),
      .k_one    (k_one),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .ext_data (data_in),
      .result   (alu_res),
      .carry    (alu_carry)
   );

   rtx_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (dst),
      .wr_data   (alu_res),
      .regs_flat (regs_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                carry_q <= 1'b0;
      else if (ctrl_true && op_sets_carry(func)) carry_q <= alu_carry;
   end

   assign carry_out = carry_q;

endmodule

// File: rtl/rtx_checker.sv
`timescale 1ns/1ps
module rtx_checker #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 4,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       k_one,
   input logic                       k_two,
   input logic [3:0]                 func,
   input logic [SEL_W-1:0]           src_a,
   input logic [SEL_W-1:0]           dst,
   input logic [NUM_REGS*DATA_W-1:0] regs_out,
   input logic                       carry_out
);

   logic [DATA_W-1:0] a_val;
   assign a_val = regs_out[src_a*DATA_W +: DATA_W];

   // R1
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (regs_out == '0) && !carry_out);

   // R2
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(k_one || k_two) |=> $stable(regs_out) && $stable(carry_out));

   // R12
   p_reserved_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (func == 4'd15) |=> $stable(regs_out) && $stable(carry_out));

   // R6
   p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (k_one || k_two) && (func == 4'd6) && (a_val == '1) |=> carry_out);

   // R10
   p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (k_one || k_two) && (func >= 4'd8) |=> $stable(carry_out));

   genvar gc;
   generate
      for (gc = 0; gc < NUM_REGS; gc++) begin : g_dest
         // R3
         p_dest_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (k_one || k_two) && (dst != SEL_W'(gc))
            |=> $stable(regs_out[gc*DATA_W +: DATA_W]));
      end
   endgenerate

endmodule

bind rtx_datapath rtx_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rtx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .k_one     (k_one),
   .k_two     (k_two),
   .func      (func),
   .src_a     (src_a),
   .dst       (dst),
   .regs_out  (regs_out),
   .carry_out (carry_out)
);

// File: tb/test_rtx_datapath.sv
`timescale 1ns/1ps
module test_rtx_datapath;

   localparam int W = 8;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         k_one = 1'b0, k_two = 1'b0, x_mode = 1'b0;
   logic [3:0]   func = 4'd0;
   logic [1:0]   src_a = 2'd0, src_b = 2'd0, dst = 2'd0;
   logic [W-1:0] data_in = '0;
   logic [N*W-1:0] regs_out;
   logic         carry_out;

   int checks = 0;
   int failures = 0;
   int m [N];
   int mc = 0;

   always #10 clk = ~clk;

   rtx_datapath i_rtx_datapath (
      .clk(clk), .rst_n(rst_n), .k_one(k_one), .k_two(k_two), .x_mode(x_mode),
      .func(func), .src_a(src_a), .src_b(src_b), .dst(dst), .data_in(data_in),
      .regs_out(regs_out), .carry_out(carry_out)
   );

   function automatic int reg_val(int i);
      return int'(regs_out[i*W +: W]);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      for (int i = 0; i < N; i++) check(tag, $sformatf("reg%0d", i), reg_val(i), m[i]);
      check(tag, "carry", int'(carry_out), mc);
   endtask

   // behavioural reference: one micro-operation per clock
   task automatic op(input int f, input int sa, input int sb, input int d,
                     input bit k1v, input bit k2v, input bit xv, input int din,
                     input string tag);
      int a, b, s, res;
      bit wr, cs;
      func = 4'(f); src_a = 2'(sa); src_b = 2'(sb); dst = 2'(d);
      k_one = k1v; k_two = k2v; x_mode = xv; data_in = W'(din);
      @(posedge clk);
      a = m[sa]; b = m[sb]; s = 0; res = 0; wr = 1'b1; cs = 1'b0;
      case (f)
         0:  res = a;
         1:  res = din % 256;
         2:  begin s = xv ? a + (255 - b) + 1 : a + b; res = s % 256; cs = 1'b1; end
         3:  res = 255 - a;
         4:  res = (256 - a) % 256;
         5:  begin s = b + (255 - a) + 1; res = s % 256; cs = 1'b1; end
         6:  begin s = a + 1; res = s % 256; cs = 1'b1; end
         7:  begin s = a + 255; res = s % 256; cs = 1'b1; end
         8:  res = a & b;
         9:  res = a | b;
         10: res = a ^ b;
         11: res = 255 - a;
         12: res = (a * 2) % 256;
         13: res = a / 2;
         14: res = k1v ? a : b;
         default: wr = 1'b0;
      endcase
      if (k1v || k2v) begin
         if (wr) m[d] = res;
         if (cs) mc = (s > 255) ? 1 : 0;
      end
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int seed;
      for (int i = 0; i < N; i++) m[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all("R1 reset");

      // R11 loads
      op(1, 0, 0, 1, 1, 0, 0, 'hAA, "R11 load");
      op(1, 0, 0, 2, 0, 1, 0, 'hF0, "R11 load");
      op(1, 0, 0, 3, 1, 0, 0, 'hC9, "R11 load");
      check("R11", "reg1 literal", reg_val(1), 'hAA);

      // R7 logic
      op(8, 1, 2, 0, 1, 0, 0, 0, "R7 and");
      check("R7", "and literal", reg_val(0), 'hA0);
      op(9, 1, 2, 0, 1, 0, 0, 0, "R7 or");
      check("R7", "or literal", reg_val(0), 'hFA);
      op(10, 1, 2, 0, 1, 0, 0, 0, "R7 xor");
      check("R7", "xor literal", reg_val(0), 'h5A);
      op(11, 1, 0, 0, 1, 0, 0, 0, "R7 not");

      // R8 shifts
      op(12, 3, 0, 0, 1, 0, 0, 0, "R8 shl");
      check("R8", "shl literal", reg_val(0), 'h92);
      op(13, 3, 0, 0, 1, 0, 0, 0, "R8 shr");
      check("R8", "shr literal", reg_val(0), 'h64);

      // R2 control expression false
      op(2, 1, 2, 0, 0, 0, 0, 0, "R2 idle add");
      check("R2", "reg0 held", reg_val(0), 'h64);

      // R4 add / subtract, R10 carry
      op(2, 1, 2, 0, 1, 0, 0, 0, "R4 add");
      check("R4", "add literal", reg_val(0), 'h9A);
      check("R10", "add carry", int'(carry_out), 1);
      op(2, 1, 2, 0, 1, 0, 1, 0, "R4 sub borrow");
      check("R4", "sub literal", reg_val(0), 'hBA);
      check("R10", "borrow carry", int'(carry_out), 0);
      op(2, 2, 1, 0, 0, 1, 1, 0, "R4 sub");
      check("R4", "sub literal2", reg_val(0), 'h46);

      // R3 conditional OR transfer via k_two only
      op(9, 1, 3, 1, 0, 1, 0, 0, "R3 cond or");
      check("R3", "or into reg1", reg_val(1), 'hEB);

      // R5 complements
      op(3, 3, 0, 0, 1, 0, 0, 0, "R5 comp1");
      check("R5", "comp1 literal", reg_val(0), 'h36);
      op(4, 3, 0, 0, 1, 0, 0, 0, "R5 comp2");
      check("R5", "comp2 literal", reg_val(0), 'h37);
      op(5, 3, 2, 0, 1, 0, 0, 0, "R5 b minus a");
      check("R5", "bsuba literal", reg_val(0), 'h27);

      // R6 wrap
      op(1, 0, 0, 0, 1, 0, 0, 'hFF, "R11 load");
      op(6, 0, 0, 0, 1, 0, 0, 0, "R6 inc wrap");
      check("R6", "inc wrap", reg_val(0), 0);
      op(7, 0, 0, 0, 1, 0, 0, 0, "R6 dec wrap");
      check("R6", "dec wrap", reg_val(0), 'hFF);
      op(7, 0, 0, 0, 1, 0, 0, 0, "R6 dec");

      // R10 carry held across logic
      op(8, 1, 2, 3, 1, 0, 0, 0, "R10 hold");

      // R9 priority transfer
      op(14, 1, 2, 0, 1, 1, 0, 0, "R9 k_one wins");
      check("R9", "got src a", reg_val(0), m[1]);
      op(14, 1, 2, 0, 0, 1, 0, 0, "R9 k_two");
      check("R9", "got src b", reg_val(0), m[2]);
      op(14, 1, 3, 0, 0, 0, 0, 0, "R2 prixfer idle");

      // R12 reserved
      op(15, 1, 2, 0, 1, 1, 0, 0, "R12 reserved");

      // R11 same source and destination, pass
      op(6, 2, 0, 2, 1, 0, 0, 0, "R11 self inc");
      op(0, 3, 0, 1, 1, 0, 0, 0, "R11 pass");

      // mixed sweep, model compared every clock
      seed = 7;
      for (int i = 0; i < 200; i++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         op((seed >> 3) % 16, (seed >> 8) % 4, (seed >> 10) % 4, (seed >> 12) % 4,
            ((seed >> 14) % 4) != 0, ((seed >> 16) % 2) != 0, ((seed >> 17) % 2) != 0,
            (seed >> 18) % 256, "R3 sweep");
      end

      // R1 reset again mid-run
      rst_n = 1'b0;
      @(posedge clk);
      for (int i = 0; i < N; i++) m[i] = 0;
      mc = 0;
      @(negedge clk);
      compare_all("R1 late reset");
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule